// File: doc/BRIEF.md
# Four-Way Set-Associative Word Cache

This block sits between a 32-bit byte-addressed processor and a slower memory. It holds 256 sets of four ways, and each way stores a valid flag, a 22-bit tag and one 32-bit word. For every request, the tags of all four ways in the selected set are compared in parallel. A one-hot hit vector then steers a 4-to-1 data multiplexor. A read hit returns data in the cycle it is presented. A read miss stalls the processor, fetches the word, fills a way and then repeats the lookup, which now hits. Writes always go to memory. A write that hits also updates the cached word. A write that misses leaves the cache untouched.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady while `cpu_stall` is high. An access completes in the cycle where `cpu_req` is high and `cpu_stall` is low. On the memory side, a request is raised on `mem_valid` and completes in the cycle `mem_ready` is high. For a read, `mem_rdata` is taken in that same cycle.

The controller has three states:
- `ST_LOOKUP` compares tags and serves read hits.
- `ST_MEM_WR` performs the write-through.
- `ST_MEM_RD` fetches a missed word.

Transitions:
- LOOKUP→MEM_WR on any write request.
- LOOKUP→MEM_RD on a read miss.
- MEM_WR→LOOKUP when memory accepts the write.
- MEM_RD→LOOKUP when memory returns the word (the fill).
- LOOKUP stays in LOOKUP when idle or on a read hit.

Replacement keeps a full recency order of the four ways in each set.

Top module: `sa4_cache`

## Requirements
- R1: After reset every way is invalid. With no request, `cpu_stall` and `mem_valid` are low, and the first read of any address misses.
- R2: Address bits 31:10 form the tag and bits 9:2 select the set. Bits 1:0 do not affect lookup, so addresses that differ only there return the same word. Addresses with equal set bits and different tags are distinct entries.
- R3: A read whose tag matches a valid way in its set completes in the presentation cycle with `cpu_stall` low, `cpu_hit` high, the stored word on `cpu_rdata`, and no memory request. At most one way matches.
- R4: A read miss raises `cpu_stall` in its first cycle. It then issues one memory read with `mem_we` low, at the request address with bits 1:0 forced to zero.
- R5: The cycle after a fill, the repeated lookup completes as a hit, with `cpu_stall` low and `cpu_rdata` equal to the fetched word.
- R6: Every write stalls until memory accepts it, then presents `cpu_wdata` at the word-aligned address with `mem_we` high. On a write hit, `cpu_hit` is high at completion and later reads return the new word.
- R7: A write miss writes memory only (`cpu_hit` low at completion). A later read of that address misses and fetches the written word.
- R8: A fill goes into an invalid way of the set when one exists, so four different tags filled into one set all hit afterwards.
- R9: When no way is invalid, a fill evicts the least recently used way. Read hits, write hits and fills each make the touched way the most recent.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_stall | output | 1 | Request not yet complete |
| cpu_hit | output | 1 | Completing access found its tag in the cache |
| cpu_rdata | output | 32 | Read word, valid on read completion |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, taken when `mem_ready` is high |

## Verification
The bench repeatedly cycles five tags through one set. This separates true recency replacement from FIFO or random choice, because a touched way must survive the next eviction while the untouched oldest way is lost. Back-to-back fills of four tags, followed by re-reads, show whether fills use empty ways instead of overwriting a live one. Directed write hit and write miss pairs, each followed by a read, show whether writes allocate and whether hit data is refreshed. Random mixed traffic over a few sets, with random memory latency and offsets, is compared against a behavioural model of memory and recency order; held-off `mem_ready` cycles exercise the handshake stability.

// File: rtl/sa4_cache_pkg.sv
`timescale 1ns/1ps
package sa4_cache_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_MEM_WR = 2'd1,
        ST_MEM_RD = 2'd2
    } ctrl_state_t;

endpackage

// File: rtl/sa4_way.sv
`timescale 1ns/1ps
// One way of the cache: valid flags, tags and data words for every set,
// with a single tag comparator for the indexed set.
module sa4_way #(
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              valid,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    // A write always carries the tag of the current address: correct for a
    // fill and unchanged for a write hit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= cmp_tag;
            data_q[idx] <= wr_data;
        end
    end

    assign valid = valid_q[idx];
    assign hit   = valid && (tag_q[idx] == cmp_tag);
    assign rdata = data_q[idx];

endmodule

// File: rtl/sa4_lru.sv
`timescale 1ns/1ps
// Per-set recency order: each way holds a rank, 0 = most recent,
// WAYS-1 = least recent. Also picks the fill victim.
module sa4_lru #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     touch_en,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    input  logic [WAYS-1:0]          valid_vec,
    output logic [$clog2(WAYS)-1:0]  victim
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0][WAY_W-1:0] rank_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] cur_rank;
    logic [WAYS-1:0][WAY_W-1:0] nxt_rank;
    logic                       found_free;
    logic [WAYS-1:0]            seen;

    assign cur_rank = rank_q[idx];

    // Ways more recent than the touched way each age by one step.
    always_comb begin
        nxt_rank = cur_rank;
        for (int w = 0; w < WAYS; w++) begin
            if (cur_rank[w] < cur_rank[touch_way]) begin
                nxt_rank[w] = WAY_W'(cur_rank[w] + 1'b1);
            end
        end
        nxt_rank[touch_way] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            rank_q[idx] <= nxt_rank;
        end
    end

    // Lowest invalid way first, otherwise the oldest way.
    always_comb begin
        victim     = '0;
        found_free = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_vec[w] && !found_free) begin
                victim     = WAY_W'(w);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int w = 0; w < WAYS; w++) begin
                if (cur_rank[w] == WAY_W'(WAYS - 1)) begin
                    victim = WAY_W'(w);
                end
            end
        end
    end

    always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            seen[cur_rank[w]] = 1'b1;
        end
    end

    AST_LRU_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        &seen); // R9

endmodule

// File: rtl/sa4_ctrl.sv
`timescale 1ns/1ps
// Access controller: lookup, write-through and miss fetch.
module sa4_ctrl
    import sa4_cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic lookup_hit,
    input  logic mem_ready,
    output logic cpu_stall,
    output logic mem_valid,
    output logic mem_we,
    output logic fill_en,
    output logic wr_hit_en,
    output logic touch_en,
    output logic touch_fill
);
    ctrl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cpu_stall  = 1'b0;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        fill_en    = 1'b0;
        wr_hit_en  = 1'b0;
        touch_en   = 1'b0;
        touch_fill = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        cpu_stall = 1'b1;
                        state_d   = ST_MEM_WR;
                    end else if (!lookup_hit) begin
                        cpu_stall = 1'b1;
                        state_d   = ST_MEM_RD;
                    end else begin
                        touch_en  = 1'b1;
                    end
                end
            end
            ST_MEM_WR: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                cpu_stall = !mem_ready;
                wr_hit_en = mem_ready && lookup_hit;
                touch_en  = mem_ready && lookup_hit;
                if (mem_ready) begin
                    state_d = ST_LOOKUP;
                end
            end
            ST_MEM_RD: begin
                mem_valid  = 1'b1;
                cpu_stall  = 1'b1;
                fill_en    = mem_ready;
                touch_en   = mem_ready;
                touch_fill = 1'b1;
                if (mem_ready) begin
                    state_d = ST_LOOKUP;
                end
            end
            default: begin
                state_d = ST_LOOKUP;
            end
        endcase
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we))); // R10

    AST_FILL_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (mem_valid && mem_ready && !mem_we)); // R4

endmodule

// File: rtl/sa4_cache.sv
`timescale 1ns/1ps
// Four-way set-associative, write-through, no-write-allocate word cache.
module sa4_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [IDX_W-1:0]             set_idx;
    logic [TAG_W-1:0]             req_tag;
    logic [WAYS-1:0]              hit_vec;
    logic [WAYS-1:0]              valid_vec;
    logic [WAYS-1:0][DATA_W-1:0]  way_rdata;
    logic [WAYS-1:0]              way_wr;
    logic [DATA_W-1:0]            way_wdata;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;
    logic [WAY_W-1:0]             touch_way;
    logic                         lookup_hit;
    logic                         fill_en;
    logic                         wr_hit_en;
    logic                         touch_en;
    logic                         touch_fill;
    logic                         unused_offset;

    assign set_idx       = cpu_addr[OFF_W +: IDX_W];
    assign req_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^cpu_addr[OFF_W-1:0];
    assign way_wdata     = fill_en ? mem_rdata : cpu_wdata;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign way_wr[g] = (fill_en && (victim == WAY_W'(g)))
                        || (wr_hit_en && hit_vec[g]);
        sa4_way #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (set_idx),
            .cmp_tag (req_tag),
            .wr_en   (way_wr[g]),
            .wr_data (way_wdata),
            .valid   (valid_vec[g]),
            .hit     (hit_vec[g]),
            .rdata   (way_rdata[g])
        );
    end

    // One-hot AND-OR multiplexor and hit way encoder.
    always_comb begin
        cpu_rdata = '0;
        hit_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                cpu_rdata = cpu_rdata | way_rdata[w];
                hit_way   = WAY_W'(w);
            end
        end
    end

    assign lookup_hit = |hit_vec;
    assign touch_way  = touch_fill ? victim : hit_way;

    sa4_lru #(
        .WAYS  (WAYS),
        .IDX_W (IDX_W)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (set_idx),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .valid_vec (valid_vec),
        .victim    (victim)
    );

    sa4_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .lookup_hit (lookup_hit),
        .mem_ready  (mem_ready),
        .cpu_stall  (cpu_stall),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .fill_en    (fill_en),
        .wr_hit_en  (wr_hit_en),
        .touch_en   (touch_en),
        .touch_fill (touch_fill)
    );

    assign cpu_hit   = cpu_req && !cpu_stall && lookup_hit;
    assign mem_addr  = {cpu_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
    assign mem_wdata = cpu_wdata;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (!cpu_req || cpu_hit)); // R5

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_stall) |-> (mem_valid && mem_we && mem_ready)); // R6

endmodule

// File: tb/sa4_cache_bench.sv
`timescale 1ns/1ps
module sa4_cache_bench;
    localparam int SETS = 256;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata;
    logic        cpu_stall, cpu_hit;
    logic [31:0] cpu_rdata;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    sa4_cache u_sa4_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_stall (cpu_stall),
        .cpu_hit   (cpu_hit),
        .cpu_rdata (cpu_rdata),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Behavioural memory and cache-content model
    logic [31:0] mem_m [logic [29:0]];
    bit          m_val  [SETS][WAYS];
    logic [21:0] m_tag  [SETS][WAYS];
    int          m_rank [SETS][WAYS];

    function automatic logic [31:0] mem_word(logic [29:0] wa);
        if (mem_m.exists(wa)) return mem_m[wa];
        return {wa[15:0], ~wa[15:0]} ^ 32'hA5C3_0000;
    endfunction

    function automatic int m_find(int s, logic [21:0] t);
        for (int w = 0; w < WAYS; w++)
            if (m_val[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic void m_touch(int s, int w);
        int r = m_rank[s][w];
        for (int j = 0; j < WAYS; j++)
            if (m_rank[s][j] < r) m_rank[s][j]++;
        m_rank[s][w] = 0;
    endfunction

    function automatic int m_victim(int s);
        for (int w = 0; w < WAYS; w++)
            if (!m_val[s][w]) return w;
        for (int w = 0; w < WAYS; w++)
            if (m_rank[s][w] == WAYS - 1) return w;
        return 0;
    endfunction

    function automatic void m_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w]  = 1'b0;
                m_rank[s][w] = w;
            end
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One processor access with a memory responder of fixed latency.
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input int lat, output bit got_miss);
        int          s = int'(addr[9:2]);
        logic [21:0] t = addr[31:10];
        int          way = m_find(s, t);
        bit          exp_hit = (way >= 0);
        int          cyc = 0;
        int          waitc = 0;
        bit          done = 0, saw_rd = 0, saw_wr = 0, first_stall = 0;
        logic [31:0] rd_addr = '0, wr_addr = '0, wr_dat = '0;
        logic [31:0] hold_addr = '0, fin_data = '0;
        logic        hold_we = 1'b0, fin_hit = 1'b0;
        logic [31:0] exp_word;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = wd;
        mem_ready = 1'b0;
        while (!done && cyc < 64) begin
            #1;
            if (mem_valid) begin
                if (waitc > 0) begin
                    chk("R10", "mem_addr held", mem_addr, hold_addr);
                    chk("R10", "mem_we held", {31'd0, mem_we}, {31'd0, hold_we});
                end
                hold_addr = mem_addr;
                hold_we   = mem_we;
                if (waitc >= lat) begin
                    mem_ready = 1'b1;
                    if (!mem_we) mem_rdata = mem_word(mem_addr[31:2]);
                end
                waitc++;
            end
            #1;
            if (cyc == 0) first_stall = cpu_stall;
            if (mem_valid && mem_ready) begin
                if (mem_we) begin
                    saw_wr  = 1;
                    wr_addr = mem_addr;
                    wr_dat  = mem_wdata;
                    mem_m[mem_addr[31:2]] = mem_wdata;
                end else begin
                    saw_rd  = 1;
                    rd_addr = mem_addr;
                end
            end
            if (!cpu_stall) begin
                done     = 1;
                fin_hit  = cpu_hit;
                fin_data = cpu_rdata;
            end
            @(negedge clk);
            mem_ready = 1'b0;
            cyc++;
        end
        cpu_req  = 1'b0;
        got_miss = first_stall;
        chk(we ? "R6" : "R3", "access completed", {31'd0, done}, 32'd1);
        if (!we) begin
            exp_word = mem_word(addr[31:2]);
            chk(exp_hit ? "R3" : "R4", "first-cycle stall", {31'd0, first_stall}, {31'd0, !exp_hit});
            chk(exp_hit ? "R3" : "R4", "memory read issued", {31'd0, saw_rd}, {31'd0, !exp_hit});
            if (!exp_hit) chk("R4", "fetch address", rd_addr, {addr[31:2], 2'b00});
            chk(exp_hit ? "R3" : "R5", "read data", fin_data, exp_word);
            chk(exp_hit ? "R3" : "R5", "cpu_hit on completion", {31'd0, fin_hit}, 32'd1);
            if (exp_hit) begin
                m_touch(s, way);
            end else begin
                way = m_victim(s);
                m_val[s][way] = 1'b1;
                m_tag[s][way] = t;
                m_touch(s, way);
            end
        end else begin
            chk("R6", "write stalls first cycle", {31'd0, first_stall}, 32'd1);
            chk("R6", "memory write issued", {31'd0, saw_wr}, 32'd1);
            chk("R6", "write address", wr_addr, {addr[31:2], 2'b00});
            chk("R6", "write data", wr_dat, wd);
            chk("R7", "no fetch on write", {31'd0, saw_rd}, 32'd0);
            chk(exp_hit ? "R6" : "R7", "cpu_hit on write", {31'd0, fin_hit}, {31'd0, exp_hit});
            if (exp_hit) m_touch(s, way);
        end
    endtask

    function automatic logic [31:0] mk_addr(logic [21:0] t, logic [7:0] s, logic [1:0] off);
        return {t, s, off};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        bit miss;
        logic [31:0] a;
        rst_n     = 1'b0;
        cpu_req   = 1'b0;
        cpu_we    = 1'b0;
        cpu_addr  = '0;
        cpu_wdata = '0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        m_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "stall in reset", {31'd0, cpu_stall}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "stall idle", {31'd0, cpu_stall}, 32'd0);
        chk("R1", "mem_valid idle", {31'd0, mem_valid}, 32'd0);
        @(negedge clk);

        // R1 / R2 / R3: first read misses, repeat hits, offsets alias
        a = 32'h0001_2344;
        access(0, a, 0, 1, miss);
        chk("R1", "first read misses", {31'd0, miss}, 32'd1);
        access(0, a, 0, 0, miss);
        chk("R3", "second read hits", {31'd0, miss}, 32'd0);
        access(0, a | 32'h3, 0, 0, miss);
        chk("R2", "offset bits ignored", {31'd0, miss}, 32'd0);
        access(0, a ^ 32'h0000_0400, 0, 0, miss);
        chk("R2", "other tag same set misses", {31'd0, miss}, 32'd1);

        // R8 / R9: five tags through set 5
        for (int k = 0; k < 4; k++) access(0, mk_addr(22'h100 + 22'(k), 8'd5, 2'd0), 0, 2, miss);
        for (int k = 0; k < 4; k++) begin
            access(0, mk_addr(22'h100 + 22'(k), 8'd5, 2'd0), 0, 0, miss);
            chk("R8", "four fills all resident", {31'd0, miss}, 32'd0);
        end
        access(0, mk_addr(22'h100, 8'd5, 2'd0), 0, 0, miss);
        access(0, mk_addr(22'h104, 8'd5, 2'd0), 0, 0, miss);
        chk("R9", "fifth tag misses", {31'd0, miss}, 32'd1);
        access(0, mk_addr(22'h101, 8'd5, 2'd0), 0, 0, miss);
        chk("R9", "oldest tag evicted", {31'd0, miss}, 32'd1);
        access(0, mk_addr(22'h100, 8'd5, 2'd0), 0, 0, miss);
        chk("R9", "recently touched tag kept", {31'd0, miss}, 32'd0);

        // R6: write hit then read back
        access(1, mk_addr(22'h100, 8'd5, 2'd0), 32'hDEAD_BEEF, 3, miss);
        access(0, mk_addr(22'h100, 8'd5, 2'd0), 0, 0, miss);
        chk("R6", "read after write hit hits", {31'd0, miss}, 32'd0);

        // R7: write miss then read
        a = mk_addr(22'h3ABCD, 8'd9, 2'd0);
        access(1, a, 32'h1234_5678, 0, miss);
        access(0, a, 0, 4, miss);
        chk("R7", "read after write miss misses", {31'd0, miss}, 32'd1);

        // R10: long memory hold-off
        access(0, mk_addr(22'h2222, 8'd77, 2'd1), 0, 6, miss);

        // Random mixed traffic
        void'($urandom(32'hC0FFEE));
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  rs;
            logic [21:0] rt;
            bit          rw;
            case ($urandom_range(2, 0))
                0: rs = 8'd3;
                1: rs = 8'd5;
                default: rs = 8'd200;
            endcase
            rt = 22'h1000 + 22'($urandom_range(5, 0)) * 22'h137;
            rw = ($urandom_range(9, 0) < 3);
            access(rw, mk_addr(rt, rs, 2'($urandom_range(3, 0))), $urandom,
                   $urandom_range(3, 0), miss);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule